// File: doc/BRIEF.md
# Forward-Link Command Serializer

This block sends one command frame from a low-frequency reader to a tag by switching the reader field on and off. The tag is powered by the field. It reads data from the length and shape of the gaps in the field. A frame holds a fixed start bit, a 4-bit command code, an optional address field and an optional 32-bit data field. The block builds this bit stream when a command is accepted and then plays it out on the field-enable output.

All timing is counted in field clocks. One field clock is `CLKS_PER_FC` system clocks; the default of 1000 gives 8 µs at 125 MHz. Every frame opens with a long field-off preamble followed by a shorter field-on interval. Each bit then has its own waveform. A one keeps the field on for the whole bit period. A zero cuts the field off and then turns it back on. After a frame the field stays on so the tag remains powered for its reply. Login and write frames are followed by a further field-on wait before the block reports completion, so the tag has time to finish the operation.

The block only sends. Capturing the tag's reply is done elsewhere.

Top module: `fwd_serializer`

## Requirements
- R1: While reset is asserted and after it is released with no command given, `fieldOn` is 1, `busy` is 0 and `done` is 0.
- R2: A `start` sampled while idle is accepted. From the next cycle `busy` is 1, and `fieldOn` is 0 for 55 field clocks and then 1 for 16 field clocks. One field clock is `CLKS_PER_FC` clock cycles.
- R3: A frame bit of value 1 holds `fieldOn` at 1 for 32 field clocks.
- R4: A frame bit of value 0 drives `fieldOn` to 0 for 16 field clocks and then to 1 for 16 field clocks.
- R5: Every frame sends a 0 start bit first, then four code bits, least significant bit first. `cmdSel` selects the command: 0 is login (code 0xC), 1 is read (code 0x9), 2 is write (code 0xA) and 3 is disable (code 0x5). Disable frames end after the code bits.
- R6: Read and write frames follow the code with the 6-bit `addr`, least significant bit first, and then one even-parity bit over those 6 bits.
- R7: Login and write frames follow the code (write: the address field) with the 32-bit `word` sent as four bytes, lowest byte first. Each byte is sent least significant bit first and is followed by its even-parity bit. Then comes a column-parity byte, which is the XOR of the four bytes, sent least significant bit first. The frame ends with a 0 stop bit.
- R8: After the last bit, `fieldOn` stays 1. For login and write, `busy` stays 1 for a further `WAIT_FC` field clocks. For read and disable, `busy` falls right after the last bit.
- R9: `done` is 1 for exactly one cycle, the first cycle in which `busy` is 0 after a frame. A new `start` may be accepted in that cycle.
- R10: `start` is ignored while `busy` is 1. `cmdSel`, `addr` and `word` are captured when the command is accepted; later changes to them have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, sampled while idle |
| cmdSel | input | 2 | Command select: 0 login, 1 read, 2 write, 3 disable |
| addr | input | ADDR_W (6) | Word address for read and write |
| word | input | WORD_W (32) | Password for login, data for write |
| fieldOn | output | 1 | Reader field enable (1 = field on) |
| busy | output | 1 | Frame or completion wait in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the inputs:
- The segment lengths and `CLKS_PER_FC` are at least 1.
- `start` may be raised in any cycle, including while a frame is running, because the control decides whether to accept it.

The stimulus issues commands only from idle or in the `done` cycle. While a frame is running, it pulses `start` once with a different command and changes `addr` and `word`, which tests the rule that these are ignored. Inputs change one time unit after the falling edge, so the reference model knows the exact edge at which a command is accepted.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    CMD_LOGIN   = 2'd0,
    CMD_READ    = 2'd1,
    CMD_WRITE   = 2'd2,
    CMD_DISABLE = 2'd3
  } cmdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a freshly built frame
    logic shift;     // advance to the next frame bit
    logic clrPresc;  // restart the field-clock prescaler
  } fwdStrobe_t;

  // command codes already carry parity and are stored mirrored
  function automatic logic [3:0] codeOf(cmdSel_e sel);
    case (sel)
      CMD_LOGIN: codeOf = 4'hC;
      CMD_READ:  codeOf = 4'h9;
      CMD_WRITE: codeOf = 4'hA;
      default:   codeOf = 4'h5;
    endcase
  endfunction

endpackage

// File: rtl/fwd_frame_build.sv
module fwd_frame_build
  import fwd_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int WORD_W   = 32,
  parameter int MAX_BITS = 57,
  parameter int LEN_W    = 7
) (
  input  cmdSel_e             cmdSel,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   word,
  output logic [MAX_BITS-1:0] frame,
  output logic [LEN_W-1:0]    frameLen
);
  localparam int BYTES = WORD_W / 8;

  logic [3:0] code;
  logic       hasAddr;
  logic       hasData;
  logic [7:0] colPar;

  assign code    = codeOf(cmdSel);
  assign hasAddr = (cmdSel == CMD_READ) || (cmdSel == CMD_WRITE);
  assign hasData = (cmdSel == CMD_LOGIN) || (cmdSel == CMD_WRITE);

  always_comb begin
    colPar = '0;
    for (int b = 0; b < BYTES; b++) colPar = colPar ^ word[b*8 +: 8];
  end

  always_comb begin
    int pos;
    frame = '0;
    pos   = 0;
    frame[pos] = 1'b0;  // start bit
    pos++;
    for (int i = 0; i < 4; i++) begin
      frame[pos] = code[i];
      pos++;
    end
    if (hasAddr) begin
      for (int i = 0; i < ADDR_W; i++) begin
        frame[pos] = addr[i];
        pos++;
      end
      frame[pos] = ^addr;
      pos++;
    end
    if (hasData) begin
      for (int b = 0; b < BYTES; b++) begin
        for (int i = 0; i < 8; i++) begin
          frame[pos] = word[b*8 + i];
          pos++;
        end
        frame[pos] = ^word[b*8 +: 8];
        pos++;
      end
      for (int i = 0; i < 8; i++) begin
        frame[pos] = colPar[i];
        pos++;
      end
      frame[pos] = 1'b0;  // stop bit
      pos++;
    end
    frameLen = LEN_W'(pos);
  end

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int MAX_BITS    = 57,
  parameter int LEN_W       = 7,
  parameter int CLKS_PER_FC = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  fwdStrobe_t          stb,
  input  logic [MAX_BITS-1:0] frame,
  input  logic [LEN_W-1:0]    frameLen,
  output logic                curBit,
  output logic                nxtBit,
  output logic                lastBit,
  output logic                fcTick
);
  localparam int PRESC_W = (CLKS_PER_FC > 1) ? $clog2(CLKS_PER_FC) : 1;
  localparam logic [PRESC_W-1:0] PRESC_TOP = PRESC_W'(CLKS_PER_FC - 1);

  logic [MAX_BITS-1:0] shReg;
  logic [LEN_W-1:0]    bitsLeft;
  logic [PRESC_W-1:0]  presc;

  always_ff @(posedge clk) begin
    if (!rstN) presc <= '0;
    else if (stb.clrPresc || presc == PRESC_TOP) presc <= '0;
    else presc <= presc + 1'b1;
  end

  assign fcTick = (presc == PRESC_TOP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      bitsLeft <= '0;
    end else if (stb.load) begin
      shReg    <= frame;
      bitsLeft <= frameLen;
    end else if (stb.shift) begin
      shReg    <= shReg >> 1;
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign curBit  = shReg[0];
  assign nxtBit  = shReg[1];
  assign lastBit = (bitsLeft == LEN_W'(1));

  // control must never step past the final frame bit
  assert_shift_in_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |-> (bitsLeft > LEN_W'(1)));

  // a load and a shift never collide
  assert_load_alone_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> !stb.shift);

endmodule

// File: rtl/fwd_control.sv
module fwd_control
  import fwd_pkg::*;
#(
  parameter int FC_PRE_OFF   = 55,
  parameter int FC_PRE_ON    = 16,
  parameter int FC_ONE       = 32,
  parameter int FC_NOTCH_OFF = 16,
  parameter int FC_NOTCH_ON  = 16,
  parameter int WAIT_FC      = 2500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  cmdSel_e    cmdSel,
  input  logic       fcTick,
  input  logic       curBit,
  input  logic       nxtBit,
  input  logic       lastBit,
  output fwdStrobe_t stb,
  output logic       fieldOn,
  output logic       busy,
  output logic       done
);
  localparam int M1    = (FC_PRE_OFF > FC_PRE_ON) ? FC_PRE_OFF : FC_PRE_ON;
  localparam int M2    = (FC_ONE > FC_NOTCH_OFF) ? FC_ONE : FC_NOTCH_OFF;
  localparam int M3    = (FC_NOTCH_ON > WAIT_FC) ? FC_NOTCH_ON : WAIT_FC;
  localparam int M12   = (M1 > M2) ? M1 : M2;
  localparam int MAXSEG = (M12 > M3) ? M12 : M3;
  localparam int CNT_W = $clog2(MAXSEG + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_OFF, ST_PRE_ON, ST_BIT_ON, ST_NOTCH_OFF, ST_NOTCH_ON, ST_HOLD
  } ctlState_e;

  ctlState_e        state;
  logic [CNT_W-1:0] fcCnt;
  logic [CNT_W-1:0] segLen;
  logic             holdReq;
  logic             segEnd;
  logic             accept;

  always_comb begin
    case (state)
      ST_PRE_OFF:   segLen = CNT_W'(FC_PRE_OFF);
      ST_PRE_ON:    segLen = CNT_W'(FC_PRE_ON);
      ST_BIT_ON:    segLen = CNT_W'(FC_ONE);
      ST_NOTCH_OFF: segLen = CNT_W'(FC_NOTCH_OFF);
      ST_NOTCH_ON:  segLen = CNT_W'(FC_NOTCH_ON);
      ST_HOLD:      segLen = CNT_W'(WAIT_FC);
      default:      segLen = CNT_W'(1);
    endcase
  end

  assign accept = (state == ST_IDLE) && start;
  assign segEnd = (state != ST_IDLE) && fcTick && (fcCnt == segLen - 1'b1);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    stb          = '0;
    stb.load     = accept;
    stb.clrPresc = accept;
    stb.shift    = segEnd && !lastBit &&
                   (state == ST_BIT_ON || state == ST_NOTCH_ON);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fieldOn <= 1'b1;
      done    <= 1'b0;
      fcCnt   <= '0;
      holdReq <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state   <= ST_PRE_OFF;
        fieldOn <= 1'b0;
        fcCnt   <= '0;
        holdReq <= (cmdSel == CMD_LOGIN) || (cmdSel == CMD_WRITE);
      end else if (segEnd) begin
        fcCnt <= '0;
        case (state)
          ST_PRE_OFF: begin
            state   <= ST_PRE_ON;
            fieldOn <= 1'b1;
          end
          ST_PRE_ON: begin
            state   <= curBit ? ST_BIT_ON : ST_NOTCH_OFF;
            fieldOn <= curBit;
          end
          ST_NOTCH_OFF: begin
            state   <= ST_NOTCH_ON;
            fieldOn <= 1'b1;
          end
          ST_BIT_ON, ST_NOTCH_ON: begin
            if (lastBit) begin
              fieldOn <= 1'b1;
              if (holdReq) state <= ST_HOLD;
              else begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end else begin
              state   <= nxtBit ? ST_BIT_ON : ST_NOTCH_OFF;
              fieldOn <= nxtBit;
            end
          end
          default: begin  // ST_HOLD
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        endcase
      end else if (busy && fcTick) begin
        fcCnt <= fcCnt + 1'b1;
      end
    end
  end

  assert_field_on_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> fieldOn);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  assert_count_in_segment_R2: assert property (@(posedge clk) disable iff (!rstN)
    fcCnt < segLen);

endmodule

// File: rtl/fwd_serializer.sv
module fwd_serializer
  import fwd_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int WORD_W       = 32,
  parameter int CLKS_PER_FC  = 1000,
  parameter int FC_PRE_OFF   = 55,
  parameter int FC_PRE_ON    = 16,
  parameter int FC_ONE       = 32,
  parameter int FC_NOTCH_OFF = 16,
  parameter int FC_NOTCH_ON  = 16,
  parameter int WAIT_FC      = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        cmdSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] word,
  output logic              fieldOn,
  output logic              busy,
  output logic              done
);
  localparam int MAX_BITS = 1 + 4 + ADDR_W + 1 + (WORD_W / 8) * 9 + 9;
  localparam int LEN_W    = $clog2(MAX_BITS + 1);

  cmdSel_e             cmdEnum;
  fwdStrobe_t          stb;
  logic [MAX_BITS-1:0] frame;
  logic [LEN_W-1:0]    frameLen;
  logic                curBit, nxtBit, lastBit, fcTick;

  assign cmdEnum = cmdSel_e'(cmdSel);

  fwd_frame_build #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)
  ) u_build (
    .cmdSel(cmdEnum), .addr(addr), .word(word),
    .frame(frame), .frameLen(frameLen)
  );

  fwd_datapath #(
    .MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .CLKS_PER_FC(CLKS_PER_FC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .frame(frame), .frameLen(frameLen),
    .curBit(curBit), .nxtBit(nxtBit), .lastBit(lastBit), .fcTick(fcTick)
  );

  fwd_control #(
    .FC_PRE_OFF(FC_PRE_OFF), .FC_PRE_ON(FC_PRE_ON), .FC_ONE(FC_ONE),
    .FC_NOTCH_OFF(FC_NOTCH_OFF), .FC_NOTCH_ON(FC_NOTCH_ON), .WAIT_FC(WAIT_FC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .cmdSel(cmdEnum),
    .fcTick(fcTick), .curBit(curBit), .nxtBit(nxtBit), .lastBit(lastBit),
    .stb(stb), .fieldOn(fieldOn), .busy(busy), .done(done)
  );

endmodule

// File: tb/test_fwd_serializer.sv
module test_fwd_serializer;
  localparam int K    = 2;
  localparam int WAIT = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmdSel = 2'd0;
  logic [5:0]  addr = '0;
  logic [31:0] word = '0;
  logic        fieldOn, busy, done;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit comparing = 1'b0;
  string extraTag = "";

  typedef struct {
    bit    f;
    bit    b;
    bit    d;
    string tag;
  } expEntry_t;

  expEntry_t expQ[$];

  always #4 clk = ~clk;

  fwd_serializer #(.CLKS_PER_FC(K), .WAIT_FC(WAIT)) i_fwd_serializer (
    .clk(clk), .rstN(rstN), .start(start), .cmdSel(cmdSel),
    .addr(addr), .word(word), .fieldOn(fieldOn), .busy(busy), .done(done)
  );

  task automatic check3(bit ef, bit eb, bit ed, string tag);
    tests++;
    if (fieldOn !== ef || busy !== eb || done !== ed) begin
      fails++;
      $display("FAIL %s%s: field/busy/done = %b%b%b expected %b%b%b (cycle %0d)",
               tag, extraTag, fieldOn, busy, done, ef, eb, ed, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (comparing) begin
      if (expQ.size() > 0) begin
        expEntry_t e;
        e = expQ.pop_front();
        check3(e.f, e.b, e.d, e.tag);
      end else begin
        check3(1'b1, 1'b0, 1'b0, "R8 idle");
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic pushSeg(bit f, int fcs, string tag);
    for (int i = 0; i < fcs * K; i++) begin
      expEntry_t e;
      e.f = f; e.b = 1'b1; e.d = 1'b0; e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  // behavioural reference of the whole frame waveform
  task automatic buildExpected(int sel, bit [5:0] a, bit [31:0] w);
    bit    bits[$];
    string tags[$];
    bit [3:0] code;
    bit [7:0] col;
    expEntry_t e;
    case (sel)
      0: code = 4'hC;
      1: code = 4'h9;
      2: code = 4'hA;
      default: code = 4'h5;
    endcase
    bits.push_back(1'b0); tags.push_back("R5");
    for (int i = 0; i < 4; i++) begin bits.push_back(code[i]); tags.push_back("R5"); end
    if (sel == 1 || sel == 2) begin
      for (int i = 0; i < 6; i++) begin bits.push_back(a[i]); tags.push_back("R6"); end
      bits.push_back(^a); tags.push_back("R6");
    end
    if (sel == 0 || sel == 2) begin
      col = 8'h00;
      for (int b = 0; b < 4; b++) begin
        bit [7:0] by;
        by = w[b*8 +: 8];
        col ^= by;
        for (int i = 0; i < 8; i++) begin bits.push_back(by[i]); tags.push_back("R7"); end
        bits.push_back(^by); tags.push_back("R7");
      end
      for (int i = 0; i < 8; i++) begin bits.push_back(col[i]); tags.push_back("R7"); end
      bits.push_back(1'b0); tags.push_back("R7");
    end
    pushSeg(1'b0, 55, "R2");
    pushSeg(1'b1, 16, "R2");
    foreach (bits[i]) begin
      if (bits[i]) pushSeg(1'b1, 32, {tags[i], "/R3"});
      else begin
        pushSeg(1'b0, 16, {tags[i], "/R4"});
        pushSeg(1'b1, 16, {tags[i], "/R4"});
      end
    end
    if (sel == 0 || sel == 2) pushSeg(1'b1, WAIT, "R8");
    e.f = 1'b1; e.b = 1'b0; e.d = 1'b1; e.tag = "R9";
    expQ.push_back(e);
  endtask

  task automatic issue(int sel, bit [5:0] a, bit [31:0] w);
    @(negedge clk); #1;
    cmdSel = 2'(sel); addr = a; word = w; start = 1'b1;
    buildExpected(sel, a, w);
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic waitIdle();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check3(1'b1, 1'b0, 1'b0, "R1 in reset");
    #1 rstN = 1'b1;
    @(negedge clk);
    check3(1'b1, 1'b0, 1'b0, "R1 after reset");
    comparing = 1'b1;
    repeat (4) @(negedge clk);

    issue(0, 6'h00, 32'h12345678);  // login
    waitIdle();
    issue(1, 6'h2A, 32'h0);         // read, back-to-back after done cycle
    waitIdle();
    repeat (3) @(negedge clk);
    issue(2, 6'h15, 32'hFFFF0000);  // write
    waitIdle();
    issue(3, 6'h3F, 32'hFFFFFFFF);  // disable
    waitIdle();
    issue(2, 6'h00, 32'h00000000);  // write all zero

    waitIdle();
    // R10: start pulse and input changes while busy
    extraTag = " R10";
    issue(1, 6'h01, 32'h0);
    repeat (300) @(negedge clk);
    #1;
    cmdSel = 2'd0; addr = 6'h3E; word = 32'hDEADBEEF; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    waitIdle();
    repeat (10) @(negedge clk);
    extraTag = "";
    issue(0, 6'h00, 32'h8001FF7E);
    waitIdle();
    repeat (5) @(negedge clk);
    comparing = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule